// File: doc/BRIEF.md
# Keyboard and Character Display Port

This block sits on the 16-bit address bus of a small processor and serves as its console. It has two sides. On the input side, a host delivers one keystroke at a time on a byte-wide strobe. The block normalises the character and holds it in a one-deep latch. The processor polls a status location for the latch and collects the character from a data location. Collecting the character empties the latch. On the output side, the processor writes a byte to a display location. The block trims the byte to 7 bits, remaps a few codes and streams the result to a terminal over a valid/ready byte channel.

The display sequencer has no FIFO. An erase character expands into three output bytes, so the processor write stays pending until the terminal has taken the last of them. The block also flags the low memory window and the high memory window to the memory devices around it. It drives no data for those windows.

Top module: `kbd_disp_port`

## Requirements
- R1: `ram_sel` is 1 exactly when the address is below 0xC000, and `rom_sel` is 1 exactly when it is at or above `ROM_BASE` (default 0xFF00). A read in either window returns 0x00 on `cpu_rdata`.
- R2: A read of 0xD011 returns 0x80 while a key is latched and 0x00 otherwise.
- R3: A read of 0xD010 while a key is latched returns the stored code with bit 7 set. The latch is empty from the next cycle on.
- R4: A read of 0xD010 with nothing latched returns 0x00. A read of any other address outside 0xD010/0xD011 also returns 0x00, and neither read changes the latch.
- R5: Before latching, an incoming 0x0A is stored as 0x0D, and both 0x7F and 0x08 are stored as 0x5F.
- R6: Before latching, codes 0x61 through 0x7A have bit 5 cleared. The neighbours 0x60 and 0x7B pass through unchanged.
- R7: A strobe that arrives while a key is latched is dropped, so the unread key is kept.
- R8: A write to 0xD012 keeps the low 7 bits of the data and emits one byte. Value 0x7F is emitted as 0x40, 0x0D is emitted as 0x0A, and any other value is emitted as itself.
- R9: A write to 0xD012 whose low 7 bits equal 0x5F emits the three bytes 0x08, 0x20, 0x08 in that order.
- R10: `cpu_wr_done` for a display write pulses in the cycle in which the last byte is taken (`disp_valid` and `disp_ready` both high). While `disp_ready` is low, `disp_valid` and `disp_data` hold. Writes to other addresses complete in the same cycle.
- R11: A synchronous active-high `rst` empties the key latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address |
| cpu_rd | input | 1 | Read access in this cycle |
| cpu_wr | input | 1 | Write request, held until `cpu_wr_done` |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the console locations, 0x00 elsewhere |
| cpu_wr_done | output | 1 | Write completion |
| ram_sel | output | 1 | Low memory window select |
| rom_sel | output | 1 | High memory window select |
| key_strobe | input | 1 | One-cycle keystroke strobe |
| key_code | input | 8 | Keystroke code |
| disp_data | output | 8 | Byte to the terminal |
| disp_valid | output | 1 | `disp_data` is valid |
| disp_ready | input | 1 | Terminal takes the byte |

## Verification
The assertions assume that the processor holds `cpu_wr`, `cpu_addr` and `cpu_wdata` steady until it sees `cpu_wr_done`, and drops the write right after. They also assume that `cpu_rd` and `cpu_wr` are never high together. The bench drives every access from a task that follows this protocol: it raises a write, waits for the completion pulse, releases the write after the consuming edge, and uses single-cycle reads. The bench raises key strobes for one cycle only. It toggles `disp_ready` only between edges.

// File: rtl/kdp_pkg.sv
package kdp_pkg;

  localparam int unsigned KDP_BYTE_W    = 8;
  localparam int unsigned KDP_ERASE_LEN = 3;

  // Normalise an incoming keystroke before it is latched.
  function automatic logic [7:0] kdp_key_fold(input logic [7:0] c);
    logic [7:0] r;
    r = c;
    if (c == 8'h0A)
      r = 8'h0D;
    else if (c == 8'h7F || c == 8'h08)
      r = 8'h5F;
    else if (c >= 8'h61 && c <= 8'h7A)
      r = c & 8'hDF;
    return r;
  endfunction

  // Map one masked display character to its emitted byte.
  function automatic logic [7:0] kdp_disp_map(input logic [6:0] v);
    logic [7:0] r;
    case (v)
      7'h7F:   r = 8'h40;
      7'h0D:   r = 8'h0A;
      default: r = {1'b0, v};
    endcase
    return r;
  endfunction

  function automatic logic kdp_is_erase(input logic [6:0] v);
    return v == 7'h5F;
  endfunction

  // Erase sequence: backspace on even steps, space on odd steps.
  function automatic logic [7:0] kdp_erase_byte(input logic [1:0] idx);
    return idx[0] ? 8'h20 : 8'h08;
  endfunction

endpackage

// File: rtl/kdp_decode.sv
module kdp_decode #(
  parameter int unsigned ADDR_W        = 16,
  parameter logic [15:0] RAM_LIMIT     = 16'hC000,
  parameter logic [15:0] ROM_BASE      = 16'hFF00,
  parameter logic [15:0] KEY_DATA_ADDR = 16'hD010,
  parameter logic [15:0] KEY_STAT_ADDR = 16'hD011,
  parameter logic [15:0] DISP_ADDR     = 16'hD012
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              ram_sel,
  output logic              rom_sel,
  output logic              key_data_sel,
  output logic              key_stat_sel,
  output logic              disp_sel
);

  always_comb begin
    ram_sel      = addr <  RAM_LIMIT[ADDR_W-1:0];
    rom_sel      = addr >= ROM_BASE[ADDR_W-1:0];
    key_data_sel = addr == KEY_DATA_ADDR[ADDR_W-1:0];
    key_stat_sel = addr == KEY_STAT_ADDR[ADDR_W-1:0];
    disp_sel     = addr == DISP_ADDR[ADDR_W-1:0];
  end

endmodule

// File: rtl/kdp_keyport.sv
module kdp_keyport
  import kdp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       key_strobe,
  input  logic [7:0] key_code,
  input  logic       take,
  output logic       key_ready,
  output logic [7:0] key_value
);

  logic       key_accept;
  logic [7:0] folded;

  assign key_accept = key_strobe && !key_ready;
  assign folded     = kdp_key_fold(key_code);

  always_ff @(posedge clk) begin
    if (rst) begin
      key_ready <= 1'b0;
      key_value <= '0;
    end else if (key_accept) begin
      key_ready <= 1'b1;
      key_value <= folded;
    end else if (take) begin
      key_ready <= 1'b0;
    end
  end

  assert_hold_pending_R7: assert property (@(posedge clk) disable iff (rst)
    key_ready && key_strobe |=> $stable(key_value) && key_ready != $past(take));

  assert_take_clears_R3: assert property (@(posedge clk) disable iff (rst)
    take |=> !key_ready);

  assert_accept_latches_R7: assert property (@(posedge clk) disable iff (rst)
    key_accept |=> key_ready);

  assert_reset_empty_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !key_ready);

endmodule

// File: rtl/kdp_dispseq.sv
module kdp_dispseq
  import kdp_pkg::*;
#(
  parameter int unsigned SEQ_LEN = KDP_ERASE_LEN
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] wdata,
  output logic [7:0] disp_data,
  output logic       disp_valid,
  input  logic       disp_ready,
  output logic       seq_done
);

  localparam int unsigned IDX_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);

  logic             busy_q;
  logic             erase_q;
  logic [6:0]       char_q;
  logic [IDX_W-1:0] idx_q;
  logic             last_byte;
  logic             beat;

  assign beat      = busy_q && disp_ready;
  assign last_byte = !erase_q || idx_q == LAST_IDX;
  assign seq_done  = beat && last_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      erase_q <= 1'b0;
      char_q  <= '0;
      idx_q   <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q  <= 1'b1;
        char_q  <= wdata[6:0];
        erase_q <= kdp_is_erase(wdata[6:0]);
        idx_q   <= '0;
      end
    end else if (beat) begin
      if (last_byte) busy_q <= 1'b0;
      else           idx_q  <= idx_q + 1'b1;
    end
  end

  always_comb begin
    disp_valid = busy_q;
    if (erase_q) disp_data = kdp_erase_byte(2'(idx_q));
    else         disp_data = kdp_disp_map(char_q);
  end

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    disp_valid && !disp_ready |=> disp_valid && $stable(disp_data));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !disp_valid);

  assert_erase_step_R9: assert property (@(posedge clk) disable iff (rst)
    beat && !seq_done |=> disp_valid && disp_data != $past(disp_data));

  assert_no_bit7_R8: assert property (@(posedge clk) disable iff (rst)
    disp_valid |-> !disp_data[7]);

endmodule

// File: rtl/kbd_disp_port.sv
module kbd_disp_port
  import kdp_pkg::*;
#(
  parameter logic [15:0] RAM_LIMIT     = 16'hC000,
  parameter logic [15:0] ROM_BASE      = 16'hFF00,
  parameter logic [15:0] KEY_DATA_ADDR = 16'hD010,
  parameter logic [15:0] KEY_STAT_ADDR = 16'hD011,
  parameter logic [15:0] DISP_ADDR     = 16'hD012
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  output logic        cpu_wr_done,
  output logic        ram_sel,
  output logic        rom_sel,
  input  logic        key_strobe,
  input  logic [7:0]  key_code,
  output logic [7:0]  disp_data,
  output logic        disp_valid,
  input  logic        disp_ready
);

  logic       key_data_sel;
  logic       key_stat_sel;
  logic       disp_sel;
  logic       key_ready;
  logic [7:0] key_value;
  logic       key_take;
  logic       disp_start;
  logic       seq_done;

  kdp_decode #(
    .ADDR_W(16), .RAM_LIMIT(RAM_LIMIT), .ROM_BASE(ROM_BASE),
    .KEY_DATA_ADDR(KEY_DATA_ADDR), .KEY_STAT_ADDR(KEY_STAT_ADDR),
    .DISP_ADDR(DISP_ADDR)
  ) u_decode (
    .addr(cpu_addr), .ram_sel(ram_sel), .rom_sel(rom_sel),
    .key_data_sel(key_data_sel), .key_stat_sel(key_stat_sel),
    .disp_sel(disp_sel)
  );

  assign key_take   = cpu_rd && key_data_sel && key_ready;
  assign disp_start = cpu_wr && disp_sel;

  kdp_keyport u_keyport (
    .clk(clk), .rst(rst), .key_strobe(key_strobe), .key_code(key_code),
    .take(key_take), .key_ready(key_ready), .key_value(key_value)
  );

  kdp_dispseq #(.SEQ_LEN(KDP_ERASE_LEN)) u_dispseq (
    .clk(clk), .rst(rst), .start(disp_start), .wdata(cpu_wdata),
    .disp_data(disp_data), .disp_valid(disp_valid),
    .disp_ready(disp_ready), .seq_done(seq_done)
  );

  always_comb begin
    cpu_rdata = 8'h00;
    if (cpu_rd) begin
      if (key_stat_sel)
        cpu_rdata = key_ready ? 8'h80 : 8'h00;
      else if (key_data_sel && key_ready)
        cpu_rdata = key_value | 8'h80;
    end
  end

  assign cpu_wr_done = (cpu_wr && !disp_sel) || seq_done;

  assert_mem_no_data_R1: assert property (@(posedge clk) disable iff (rst)
    cpu_rd && (ram_sel || rom_sel) |-> cpu_rdata == 8'h00);

  assert_empty_read_zero_R4: assert property (@(posedge clk) disable iff (rst)
    cpu_rd && !key_ready |-> cpu_rdata == 8'h00);

  assert_pending_status_R2: assert property (@(posedge clk) disable iff (rst)
    key_ready && cpu_rd && key_stat_sel |-> cpu_rdata[7]);

  assert_done_needs_take_R10: assert property (@(posedge clk) disable iff (rst)
    cpu_wr && disp_sel && cpu_wr_done |-> disp_valid && disp_ready);

endmodule

// File: tb/kbd_disp_port_bench.sv
module kbd_disp_port_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cpu_addr;
  logic        cpu_rd, cpu_wr;
  logic [7:0]  cpu_wdata;
  logic [7:0]  cpu_rdata;
  logic        cpu_wr_done, ram_sel, rom_sel;
  logic        key_strobe;
  logic [7:0]  key_code;
  logic [7:0]  disp_data;
  logic        disp_valid, disp_ready;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  kbd_disp_port u_kbd_disp_port (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_wr_done(cpu_wr_done), .ram_sel(ram_sel), .rom_sel(rom_sel),
    .key_strobe(key_strobe), .key_code(key_code), .disp_data(disp_data),
    .disp_valid(disp_valid), .disp_ready(disp_ready)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h, expected 0x%0h", req, act, exp);
    end
  endtask

  // Expected stored key, written as range tests.
  function automatic logic [7:0] exp_key(input logic [7:0] c);
    if (c inside {8'h7F, 8'h08}) return 8'h5F;
    if (c == 8'h0A)              return 8'h0D;
    if (c inside {[8'h61:8'h7A]}) return c - 8'h20;
    return c;
  endfunction

  task automatic send_key(input logic [7:0] c);
    @(negedge clk);
    key_strobe = 1'b1;
    key_code   = c;
    @(negedge clk);
    key_strobe = 1'b0;
  endtask

  task automatic cpu_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a;
    cpu_rd   = 1'b1;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic key_roundtrip(input logic [7:0] c, input string req);
    logic [7:0] d;
    send_key(c);
    cpu_read(16'hD010, d);
    check(d == (exp_key(c) | 8'h80), req, d, exp_key(c) | 8'h80);
  endtask

  // Display write; expects n bytes packed first-in-lowest in exp.
  task automatic disp_write(input logic [7:0] v, input int n, input logic [23:0] exp,
                            input string req);
    int got = 0;
    logic done = 1'b0;
    @(negedge clk);
    cpu_addr  = 16'hD012;
    cpu_wdata = v;
    cpu_wr    = 1'b1;
    for (int i = 0; i < 20 && !done; i++) begin
      @(negedge clk);
      #1;
      if (disp_valid && disp_ready) begin
        if (got < 3)
          check(disp_data == exp[got*8 +: 8], req, disp_data, exp[got*8 +: 8]);
        got++;
      end
      if (cpu_wr_done) done = 1'b1;
    end
    check(done && got == n, "R10 completion count", got, n);
    @(posedge clk);
    #1 cpu_wr = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    cpu_read(16'hD011, d);
    check(d == 8'h00, "R11 status after reset", d, 8'h00);
    cpu_read(16'hD010, d);
    check(d == 8'h00, "R4 data read empty", d, 8'h00);
  endtask

  task automatic t_decode;
    logic [15:0] addrs [6] = '{16'h0000, 16'hBFFF, 16'hC000, 16'hD010, 16'hFF00, 16'hFFFF};
    logic        ram_e [6] = '{1, 1, 0, 0, 0, 0};
    logic        rom_e [6] = '{0, 0, 0, 0, 1, 1};
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      cpu_addr = addrs[i];
      #1;
      check(ram_sel == ram_e[i], "R1 ram_sel", ram_sel, ram_e[i]);
      check(rom_sel == rom_e[i], "R1 rom_sel", rom_sel, rom_e[i]);
    end
  endtask

  task automatic t_status_and_take;
    logic [7:0] d;
    send_key(8'h61);
    cpu_read(16'hD011, d);
    check(d == 8'h80, "R2 status pending", d, 8'h80);
    cpu_read(16'hD013, d);
    check(d == 8'h00, "R4 other io read", d, 8'h00);
    cpu_read(16'h1234, d);
    check(d == 8'h00, "R1 ram read no data", d, 8'h00);
    cpu_read(16'hD011, d);
    check(d == 8'h80, "R4 stray reads keep key", d, 8'h80);
    cpu_read(16'hD010, d);
    check(d == 8'hC1, "R3 R6 data read", d, 8'hC1);
    cpu_read(16'hD011, d);
    check(d == 8'h00, "R3 status cleared", d, 8'h00);
    cpu_read(16'hD010, d);
    check(d == 8'h00, "R4 second data read", d, 8'h00);
  endtask

  task automatic t_fold;
    key_roundtrip(8'h0A, "R5 LF");
    key_roundtrip(8'h7F, "R5 DEL");
    key_roundtrip(8'h08, "R5 BS");
    key_roundtrip(8'h7A, "R6 z");
    key_roundtrip(8'h7B, "R6 above range");
    key_roundtrip(8'h60, "R6 below range");
    key_roundtrip(8'h35, "R6 digit");
  endtask

  task automatic t_no_overwrite;
    logic [7:0] d;
    send_key(8'h41);
    send_key(8'h42);
    cpu_read(16'hD010, d);
    check(d == 8'hC1, "R7 pending key kept", d, 8'hC1);
  endtask

  task automatic t_display;
    disp_write(8'h41, 1, 24'h000041, "R8 plain");
    disp_write(8'hC1, 1, 24'h000041, "R8 mask");
    disp_write(8'h7F, 1, 24'h000040, "R8 DEL");
    disp_write(8'hFF, 1, 24'h000040, "R8 masked DEL");
    disp_write(8'h0D, 1, 24'h00000A, "R8 CR");
    disp_write(8'h5F, 3, 24'h082008, "R9 erase");
    disp_write(8'hDF, 3, 24'h082008, "R9 masked erase");
  endtask

  task automatic t_stall;
    logic [7:0] first;
    disp_ready = 1'b0;
    @(negedge clk);
    cpu_addr  = 16'hD012;
    cpu_wdata = 8'h5F;
    cpu_wr    = 1'b1;
    @(negedge clk);
    #1 first = disp_data;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      check(disp_valid && disp_data == first, "R10 hold while stalled", disp_data, first);
      check(!cpu_wr_done, "R10 no done while stalled", cpu_wr_done, 0);
    end
    disp_ready = 1'b1;
    @(negedge clk);
    #1 check(disp_data == 8'h20, "R9 second byte after stall", disp_data, 8'h20);
    @(negedge clk);
    #1 check(cpu_wr_done, "R10 done on last byte", cpu_wr_done, 1);
    @(posedge clk);
    #1 cpu_wr = 1'b0;
    @(negedge clk);
    #1 check(!disp_valid, "R10 idle after done", disp_valid, 0);
  endtask

  task automatic t_other_write;
    @(negedge clk);
    cpu_addr  = 16'h0200;
    cpu_wdata = 8'h55;
    cpu_wr    = 1'b1;
    #1 check(cpu_wr_done && !disp_valid, "R10 immediate non-display write", cpu_wr_done, 1);
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic t_reset_clears;
    logic [7:0] d;
    send_key(8'h51);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    cpu_read(16'hD011, d);
    check(d == 8'h00, "R11 reset empties latch", d, 8'h00);
  endtask

  initial begin
    rst = 1'b1; cpu_addr = '0; cpu_rd = 0; cpu_wr = 0; cpu_wdata = '0;
    key_strobe = 0; key_code = '0; disp_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_decode();
    t_status_and_take();
    t_fold();
    t_no_overwrite();
    t_display();
    t_stall();
    t_other_write();
    t_reset_clears();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got 0x0, expected 0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule